// File: doc/BRIEF.md
# Cassette Phase-Encoding Modem

This block sits between a serial USART and a cassette recorder. It has no clock of its own for bit timing. A strobe that fires once per tick of a 2400 Hz time base drives it, and it does nothing between strobes.

When recording, it combines the transmit bit with a phase that toggles on every tick. The result is a Manchester-like line level for the tape. The block pulses the USART transmit clock on every second tick.

When playing, it takes an already-thresholded tape level and stores one sample as a reference. It then waits for the level to move away from that reference. The direction of the move becomes the received bit, and the block pulses the receive clock.

When the recorder is neither playing nor recording, a free-running line clock keeps the USART transmit clock running. A mode switch can hand the serial port to a direct line, which parks all of this logic.

Top module: `cmodem`

## Requirements
- R1: After reset, `tape_o` is 0, `rxd_o` is 1 and both clock pulses are low. The tape phase and the line phase are both 1, and the reference level is 0.
- R2: On a tick in record mode (`rec_i`=1, `play_i`=0, `line_sel_i`=0), `tape_o` becomes `txd_i` XOR the tape phase held before the tick, and the tape phase then inverts.
- R3: On a record-mode tick where the tape phase was 0, `txc_o` is high for exactly one cycle after the tick. Where the phase was 1, no pulse is issued.
- R4: On a play-mode tick (`play_i`=1, `line_sel_i`=0) with tape phase 1, `tape_lvl_i` is stored as the reference, the phase goes to 0, and no receive pulse occurs.
- R5: On a play-mode tick with phase 0, a level equal to the reference does nothing. A level that differs sets `rxd_o` to 1 for a low-to-high change or 0 for a high-to-low change, gives a one-cycle `rxc_o` pulse, and returns the phase to 1.
- R6: On a tick with `play_i`=0, `rec_i`=0 and `line_sel_i`=0, the tape phase is forced to 1. The line phase inverts, and `txc_o` pulses when the line phase was 0.
- R7: While `line_sel_i`=1, ticks produce no pulses and change no state or output.
- R8: When `play_i` and `rec_i` are both 1, the block acts in play mode and `tape_o` holds.
- R9: Without a tick, no pulse is issued and the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe at 2400 Hz |
| tape_lvl_i | input | 1 | Thresholded tape input level |
| play_i | input | 1 | Recorder is playing |
| rec_i | input | 1 | Recorder is recording |
| txd_i | input | 1 | USART transmit data bit |
| line_sel_i | input | 1 | 1 selects the direct serial line, which parks the tape logic |
| tape_o | output | 1 | Tape output level |
| rxd_o | output | 1 | Received data bit toward the USART |
| txc_o | output | 1 | USART transmit clock pulse |
| rxc_o | output | 1 | USART receive clock pulse |

## Verification
The bench targets the following corner cases, each with the symptom a faulty design would show:

- **Phase after record.** A record run can leave the tape phase at 0. A design that does not force the phase back to 1 on idle ticks would start the next recording with an inverted level and a misplaced transmit pulse.
- **Repeated levels in play.** A decoder that compares against the previous sample, rather than the held reference, would emit bits when the level repeats.
- **Transition polarity.** A decoder that inverts polarity would flip every received bit.
- **Both controls asserted.** With play and record high together, a design that gives record priority would disturb the tape output.
- **Direct-line mode.** A design that lets ticks through in this mode would clock the USART spuriously or lose the line phase.

// File: rtl/cmodem_pkg.sv
package cmodem_pkg;
  typedef enum logic [1:0] {
    MODE_PARK = 2'd0,
    MODE_PLAY = 2'd1,
    MODE_REC  = 2'd2,
    MODE_IDLE = 2'd3
  } cm_mode_e;
endpackage

// File: rtl/cmodem_mode.sv
module cmodem_mode
  import cmodem_pkg::*;
(
  input  logic     play_i,
  input  logic     rec_i,
  input  logic     line_sel_i,
  output cm_mode_e mode_o
);
  // play wins over record
  always_comb begin
    if (line_sel_i)  mode_o = MODE_PARK;
    else if (play_i) mode_o = MODE_PLAY;
    else if (rec_i)  mode_o = MODE_REC;
    else             mode_o = MODE_IDLE;
  end
endmodule

// File: rtl/cmodem_phase.sv
module cmodem_phase
  import cmodem_pkg::*;
#(
  parameter logic PH_RST = 1'b1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  cm_mode_e mode_i,
  input  logic     diff_i,
  output logic     ph_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_o <= PH_RST;
    end else if (tick_i) begin
      unique case (mode_i)
        MODE_PLAY: if (ph_o) ph_o <= 1'b0;
                   else if (diff_i) ph_o <= 1'b1;
        MODE_REC:  ph_o <= ~ph_o;
        MODE_IDLE: ph_o <= 1'b1;
        default:   ph_o <= ph_o;
      endcase
    end
  end
endmodule

// File: rtl/cmodem_rx.sv
module cmodem_rx
  import cmodem_pkg::*;
#(
  parameter logic REF_RST = 1'b0,
  parameter logic RXD_RST = 1'b1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  cm_mode_e mode_i,
  input  logic     ph_i,
  input  logic     lvl_i,
  output logic     diff_o,
  output logic     rxd_o,
  output logic     rxc_o
);
  logic ref_q;

  assign diff_o = lvl_i ^ ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= REF_RST;
      rxd_o <= RXD_RST;
      rxc_o <= 1'b0;
    end else begin
      rxc_o <= 1'b0;
      if (tick_i && mode_i == MODE_PLAY) begin
        if (ph_i) begin
          ref_q <= lvl_i;
        end else if (diff_o) begin
          rxd_o <= lvl_i; // rising edge gives 1, falling gives 0
          rxc_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cmodem_tx.sv
module cmodem_tx
  import cmodem_pkg::*;
#(
  parameter logic TAPE_RST = 1'b0,
  parameter logic LPH_RST  = 1'b1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  cm_mode_e mode_i,
  input  logic     ph_i,
  input  logic     txd_i,
  output logic     tape_o,
  output logic     txc_o
);
  logic line_ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tape_o    <= TAPE_RST;
      txc_o     <= 1'b0;
      line_ph_q <= LPH_RST;
    end else begin
      txc_o <= 1'b0;
      if (tick_i) begin
        unique case (mode_i)
          MODE_REC: begin
            tape_o <= txd_i ^ ph_i;
            txc_o  <= ~ph_i;
          end
          MODE_IDLE: begin
            txc_o     <= ~line_ph_q;
            line_ph_q <= ~line_ph_q;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmodem.sv
module cmodem
  import cmodem_pkg::*;
#(
  parameter logic TAPE_RST = 1'b0,
  parameter logic RXD_RST  = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic tape_lvl_i,
  input  logic play_i,
  input  logic rec_i,
  input  logic txd_i,
  input  logic line_sel_i,
  output logic tape_o,
  output logic rxd_o,
  output logic txc_o,
  output logic rxc_o
);
  localparam logic PH_RST  = 1'b1;
  localparam logic REF_RST = 1'b0;

  cm_mode_e mode;
  logic     tape_ph;
  logic     diff;

  cmodem_mode u_mode (
    .play_i(play_i), .rec_i(rec_i), .line_sel_i(line_sel_i), .mode_o(mode)
  );

  cmodem_phase #(.PH_RST(PH_RST)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .mode_i(mode),
    .diff_i(diff), .ph_o(tape_ph)
  );

  cmodem_rx #(.REF_RST(REF_RST), .RXD_RST(RXD_RST)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .mode_i(mode),
    .ph_i(tape_ph), .lvl_i(tape_lvl_i), .diff_o(diff), .rxd_o(rxd_o),
    .rxc_o(rxc_o)
  );

  cmodem_tx #(.TAPE_RST(TAPE_RST), .LPH_RST(PH_RST)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .mode_i(mode),
    .ph_i(tape_ph), .txd_i(txd_i), .tape_o(tape_o), .txc_o(txc_o)
  );
endmodule

// File: rtl/cmodem_chk.sv
module cmodem_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic tape_lvl_i,
  input logic play_i,
  input logic rec_i,
  input logic txd_i,
  input logic line_sel_i,
  input logic tape_o,
  input logic rxd_o,
  input logic txc_o,
  input logic rxc_o,
  input logic tape_ph
);
  a_r2_rec_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && rec_i && !play_i && !line_sel_i) |=>
      (tape_o == ($past(txd_i) ^ $past(tape_ph))) && (tape_ph != $past(tape_ph)));

  a_r3_rec_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && rec_i && !play_i && !line_sel_i) |=> (txc_o == !$past(tape_ph)));

  a_r5_rx_polarity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxc_o |-> (rxd_o == $past(tape_lvl_i)) && $past(play_i));

  a_r6_idle_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !play_i && !rec_i && !line_sel_i) |=> tape_ph);

  a_r7_line_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && line_sel_i) |=> !txc_o && !rxc_o && $stable(tape_o) && $stable(rxd_o)
      && $stable(tape_ph));

  a_r8_play_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && play_i && !line_sel_i) |=> $stable(tape_o) && !txc_o);

  a_r9_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !txc_o && !rxc_o && $stable(tape_o) && $stable(rxd_o));

  a_r9_pulse_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({txc_o, rxc_o}));
endmodule

bind cmodem cmodem_chk i_cmodem_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .tape_lvl_i(tape_lvl_i),
  .play_i(play_i), .rec_i(rec_i), .txd_i(txd_i), .line_sel_i(line_sel_i),
  .tape_o(tape_o), .rxd_o(rxd_o), .txc_o(txc_o), .rxc_o(rxc_o),
  .tape_ph(tape_ph)
);

// File: tb/test_cmodem.sv
module test_cmodem;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, lvl = 1'b0, play = 1'b0, rec = 1'b0, txd = 1'b0, lsel = 1'b0;
  logic tape, rxd, txc, rxc;
  int   n_run = 0, n_fail = 0;

  // bench model state, built from the requirements
  logic m_ph, m_lph, m_ref, m_tape, m_rxd;

  always #4 clk = ~clk;

  cmodem i_cmodem (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .tape_lvl_i(lvl), .play_i(play),
    .rec_i(rec), .txd_i(txd), .line_sel_i(lsel), .tape_o(tape), .rxd_o(rxd),
    .txc_o(txc), .rxc_o(rxc)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // one tick under the current inputs, with the expected outcome computed first
  task automatic step(input string req);
    logic e_txc = 1'b0, e_rxc = 1'b0;
    if (!lsel) begin
      if (play) begin
        if (m_ph) begin m_ref = lvl; m_ph = 1'b0; end
        else if (lvl != m_ref) begin m_rxd = lvl; e_rxc = 1'b1; m_ph = 1'b1; end
      end else if (rec) begin
        m_tape = txd ^ m_ph; e_txc = !m_ph; m_ph = !m_ph;
      end else begin
        m_ph = 1'b1; e_txc = !m_lph; m_lph = !m_lph;
      end
    end
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    chk(req, "tape_o", tape, m_tape);
    chk(req, "rxd_o", rxd, m_rxd);
    chk(req, "txc_o", txc, e_txc);
    chk(req, "rxc_o", rxc, e_rxc);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick = 1'b0; play = 1'b0; rec = 1'b0; lsel = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_ph = 1'b1; m_lph = 1'b1; m_ref = 1'b0; m_tape = 1'b0; m_rxd = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();  // R1
    do_reset();
    chk("R1", "tape_o", tape, 1'b0);
    chk("R1", "rxd_o", rxd, 1'b1);
    chk("R1", "txc_o", txc, 1'b0);
    chk("R1", "rxc_o", rxc, 1'b0);
  endtask

  task automatic t_record();  // R2 R3
    logic [7:0] pat = 8'b1011_0010;
    do_reset();
    rec = 1'b1;
    for (int i = 0; i < 8; i++) begin
      txd = pat[i];
      step(i[0] ? "R3" : "R2");
    end
    step("R2");  // leaves tape phase at 0
    rec = 1'b0;
  endtask

  task automatic t_idle();  // R6
    step("R6");  // phase forced to 1, line phase 1 -> no pulse
    step("R6");
    step("R6");
    rec = 1'b1; txd = 1'b0;
    step("R6");  // expects txd^1 with no pulse
    rec = 1'b0;
  endtask

  task automatic t_play();  // R4 R5
    do_reset();
    play = 1'b1;
    lvl = 1'b0; step("R4");
    lvl = 1'b0; step("R5");
    lvl = 1'b0; step("R5");
    lvl = 1'b1; step("R5");
    lvl = 1'b1; step("R4");
    lvl = 1'b1; step("R5");
    lvl = 1'b0; step("R5");
    lvl = 1'b0; step("R4");
    lvl = 1'b1; step("R5");
    play = 1'b0;
  endtask

  task automatic t_both();  // R8
    do_reset();
    rec = 1'b1; txd = 1'b1; step("R2");  // tape_o becomes 0
    play = 1'b1;
    lvl = 1'b1; step("R8");
    lvl = 1'b0; step("R8");
    chk("R8", "tape_o held", tape, 1'b0);
    play = 1'b0; rec = 1'b0;
  endtask

  task automatic t_line();  // R7
    do_reset();
    step("R6");  // line phase -> 0
    lsel = 1'b1; play = 1'b1; lvl = 1'b1;
    step("R7"); step("R7");
    play = 1'b0; rec = 1'b1; txd = 1'b1;
    step("R7");
    rec = 1'b0; step("R7");
    lsel = 1'b0;
    step("R7");  // line phase kept at 0: pulse expected now
  endtask

  task automatic t_notick();  // R9
    do_reset();
    rec = 1'b1; txd = 1'b1;
    repeat (5) begin
      @(negedge clk);
      chk("R9", "txc_o", txc, 1'b0);
      chk("R9", "tape_o", tape, 1'b0);
    end
    rec = 1'b0; play = 1'b1; lvl = 1'b1;
    repeat (5) begin
      @(negedge clk);
      chk("R9", "rxc_o", rxc, 1'b0);
      chk("R9", "rxd_o", rxd, 1'b1);
    end
    play = 1'b0;
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_record();
    t_idle();
    t_play();
    t_both();
    t_line();
    t_notick();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule